// File: doc/BRIEF.md
# UART Interrupt Mask and Status Controller

This block collects the fourteen interrupt sources of one UART channel and turns them into a single interrupt line. The UART datapath reports each event as a one-cycle pulse on a vector. When the mask bit of a source is set, its pulse is latched into a sticky status register. Software changes the mask only through two strobe registers. One strobe register sets mask bits and the other clears them. Software clears status bits by writing ones.

A separate raw view returns the level conditions that the datapath drives, whatever the mask holds. Software can therefore poll FIFO and trigger states without enabling their interrupts. The bus is a plain register port with a write strobe, a read strobe, a word address and data as wide as the source vector. Read data is combinational from the current register state.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A write to word address 0 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R2: A write to word address 1 clears every mask bit whose data bit is 1. Other mask bits keep their value.
- R3: A read of address 0 or address 1 returns zero.
- R4: The mask is read at address 2 and cannot be written there. A write to address 2 leaves the mask unchanged.
- R5: An event pulse on bit i sets status bit i only if mask bit i is set at that clock edge. The source bits, from bit 0 upward, are: RX trigger, RX empty, RX full, TX empty, TX full, overrun, framing, parity, RX timeout, modem change, TX trigger, TX nearly full, TX overflow, RX break.
- R6: The status is read at address 3. A write to address 3 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R7: If a masked-in event pulse and a write-one clear reach the same status bit in the same cycle, the bit stays set.
- R8: A read of address 4 returns the raw condition input unchanged, whatever the mask holds.
- R9: irqOut is a register. It takes the OR of all bits of (status AND mask) at each clock edge, so it follows the status and mask by one cycle.
- R10: After reset the mask and the status are zero and irqOut is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wrData | input | 14 | Write data |
| rdData | output | 14 | Read data, zero when rdEn is low |
| evtPulse | input | 14 | One-cycle event pulses from the UART datapath |
| rawCond | input | 14 | Level conditions from the datapath, for the raw view |
| irqOut | output | 1 | Interrupt request |

## Verification
A write or an event pulse presented before a rising edge changes the mask or the status at that edge. A read at the following falling edge already sees the new value, because read data is combinational. irqOut lags by one more edge. The bench therefore checks it twice: at the first falling edge after the stimulus it must still hold the old value, and one cycle later it must hold the new one. All inputs change on falling edges, and the read monitor compares one time step after each falling edge, so each queued expectation is matched against the read strobe of that same cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADR_ENA  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_DIS  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_MASK = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_STAT = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADR_RAW  = 3'd4;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MASK = 2'd1,
    RD_STAT = 2'd2,
    RD_RAW  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   setMask;
    logic   clrMask;
    logic   clrStat;
    rdSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  output ctrlStrb_t             strb
);

  always_comb begin
    strb.setMask = wrEn && (addr == ADR_ENA);
    strb.clrMask = wrEn && (addr == ADR_DIS);
    strb.clrStat = wrEn && (addr == ADR_STAT);
    strb.rdSel   = RD_NONE;
    if (rdEn) begin
      unique case (addr)
        ADR_MASK: strb.rdSel = RD_MASK;
        ADR_STAT: strb.rdSel = RD_STAT;
        ADR_RAW:  strb.rdSel = RD_RAW;
        default:  strb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
#(
  parameter int NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrb_t          strb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] rawCond,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] statusQ,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] clrBits;
  logic [NUM_SRC-1:0] setBits;

  always_comb begin
    maskNext = maskQ;
    if (strb.setMask) maskNext = maskQ | wrData;
    if (strb.clrMask) maskNext = maskQ & ~wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) maskQ <= '0;
    else        maskQ <= maskNext;
  end

  assign clrBits = strb.clrStat ? wrData : '0;
  assign setBits = evtPulse & maskQ;

  // One sticky cell per source; a set in the same cycle wins over the clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          statusQ[i] <= 1'b0;
      else if (setBits[i]) statusQ[i] <= 1'b1;
      else if (clrBits[i]) statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqOut <= 1'b0;
    else        irqOut <= |(statusQ & maskQ);
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_MASK: rdData = maskQ;
      RD_STAT: rdData = statusQ;
      RD_RAW:  rdData = rawCond;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int NUM_SRC = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NUM_SRC-1:0]    wrData,
  output logic [NUM_SRC-1:0]    rdData,
  input  logic [NUM_SRC-1:0]    evtPulse,
  input  logic [NUM_SRC-1:0]    rawCond,
  output logic                  irqOut
);

  ctrlStrb_t          strb;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] statusQ;

  uirq_ctrl u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  uirq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wrData   (wrData),
    .evtPulse (evtPulse),
    .rawCond  (rawCond),
    .rdData   (rdData),
    .maskQ    (maskQ),
    .statusQ  (statusQ),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
  import uirq_pkg::*;
#(
  parameter int NUM_SRC = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [NUM_SRC-1:0]    wrData,
  input logic [NUM_SRC-1:0]    rdData,
  input logic [NUM_SRC-1:0]    evtPulse,
  input logic [NUM_SRC-1:0]    rawCond,
  input logic [NUM_SRC-1:0]    maskQ,
  input logic [NUM_SRC-1:0]    statusQ,
  input logic                  irqOut
);

  a_r1_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADR_ENA) |=> ((maskQ & $past(wrData)) == $past(wrData)));

  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADR_DIS) |=> ((maskQ & $past(wrData)) == '0));

  a_r3_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && (addr == ADR_ENA || addr == ADR_DIS)) |-> (rdData == '0));

  a_r4_mask_only_by_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && (addr == ADR_ENA || addr == ADR_DIS)) |=> $stable(maskQ));

  a_r5_no_set_without_mask: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(evtPulse & maskQ)) == '0));

  a_r6_clear_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADR_STAT) |=>
      ((statusQ & $past(wrData) & ~$past(evtPulse & maskQ)) == '0));

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evtPulse & maskQ) & ~statusQ) == '0));

  a_r8_raw_view: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == ADR_RAW) |-> (rdData == rawCond));

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irqOut == $past(|(statusQ & maskQ))));

endmodule

bind uart_irq_ctrl uirq_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .wrData   (wrData),
  .rdData   (rdData),
  .evtPulse (evtPulse),
  .rawCond  (rawCond),
  .maskQ    (maskQ),
  .statusQ  (statusQ),
  .irqOut   (irqOut)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/100ps
module uart_irq_ctrl_tb;
  import uirq_pkg::*;

  localparam int NS = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [2:0]    addr = '0;
  logic [NS-1:0] wrData = '0;
  logic [NS-1:0] rdData;
  logic [NS-1:0] evtPulse = '0;
  logic [NS-1:0] rawCond = '0;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [NS-1:0] expQ[$];
  string         tagQ[$];

  always #2.5 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtPulse(evtPulse),
    .rawCond(rawCond), .irqOut(irqOut)
  );

  // Monitor: pops one expected item for every read strobe.
  logic [NS-1:0] monExp;
  string         monTag;
  always @(negedge clk) begin
    #1;
    if (rdEn) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL unexpected read: got %h exp nothing", rdData);
      end else begin
        monExp = expQ.pop_front();
        monTag = tagQ.pop_front();
        if (rdData !== monExp) begin
          nFails++;
          $display("FAIL %s read addr %0d: got %h exp %h", monTag, addr, rdData, monExp);
        end
      end
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [NS-1:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input logic [NS-1:0] e);
    @(negedge clk); evtPulse = e;
    @(negedge clk); evtPulse = '0;
  endtask

  task automatic wrPulse(input logic [2:0] a, input logic [NS-1:0] d, input logic [NS-1:0] e);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d; evtPulse = e;
    @(negedge clk); wrEn = 1'b0; wrData = '0; evtPulse = '0;
  endtask

  task automatic rdReg(input logic [2:0] a, input logic [NS-1:0] e, input string tag);
    @(negedge clk); rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic irqNow(input logic e, input string tag);
    #1;
    nChecks++;
    if (irqOut !== e) begin
      nFails++;
      $display("FAIL %s irqOut: got %b exp %b", tag, irqOut, e);
    end
  endtask

  initial begin
    #100000;
    nFails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irqNow(1'b0, "R10");
    rdReg(ADR_MASK, 14'h0000, "R10");
    rdReg(ADR_STAT, 14'h0000, "R10");

    pulse(14'h3FFF);                       // all sources masked off
    rdReg(ADR_STAT, 14'h0000, "R5");

    wrReg(ADR_ENA, 14'h0005);
    rdReg(ADR_MASK, 14'h0005, "R1");
    wrReg(ADR_ENA, 14'h0010);
    rdReg(ADR_MASK, 14'h0015, "R1");

    rdReg(ADR_ENA, 14'h0000, "R3");
    rdReg(ADR_DIS, 14'h0000, "R3");

    wrReg(ADR_MASK, 14'h3FFF);
    rdReg(ADR_MASK, 14'h0015, "R4");

    pulse(14'h0003);                       // bit0 enabled, bit1 not
    irqNow(1'b0, "R9");
    rdReg(ADR_STAT, 14'h0001, "R5");
    irqNow(1'b1, "R9");

    rawCond = 14'h2A0A;
    rdReg(ADR_RAW, 14'h2A0A, "R8");
    rawCond = 14'h0000;

    wrReg(ADR_STAT, 14'h0000);
    rdReg(ADR_STAT, 14'h0001, "R6");
    wrReg(ADR_STAT, 14'h0001);
    irqNow(1'b1, "R9");
    rdReg(ADR_STAT, 14'h0000, "R6");
    irqNow(1'b0, "R9");

    pulse(14'h0004);
    wrPulse(ADR_STAT, 14'h0004, 14'h0004);
    rdReg(ADR_STAT, 14'h0004, "R7");
    wrPulse(ADR_STAT, 14'h0004, 14'h0001);
    rdReg(ADR_STAT, 14'h0001, "R6");

    wrReg(ADR_DIS, 14'h0001);
    rdReg(ADR_MASK, 14'h0014, "R2");
    rdReg(ADR_STAT, 14'h0001, "R2");
    irqNow(1'b0, "R2");

    wrReg(ADR_ENA, 14'h2000);
    pulse(14'h2000);                       // RX break, top source bit
    rdReg(ADR_STAT, 14'h2001, "R5");
    irqNow(1'b1, "R9");

    @(negedge clk); #2;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard: got %0d pending exp 0", expQ.size());
    end
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule